// File: doc/BRIEF.md
# Target Retry and Disconnect Timers

This block watches how long a bus target keeps an initiator waiting inside a transaction. It ends the transaction with a retry or a disconnect when that wait runs past a programmed limit. A start strobe opens a transaction and a direction flag selects which wait applies first. On a read, the wait lasts until the first data word is ready. On a write, it lasts until the input buffer reports free space. Once that first condition is met, a second timer takes over. It bounds the gap between consecutive data beats and is reloaded by every beat.

Both limits are 8-bit programmable values, so each wait can stretch to 255 clocks. That is well past the customary protocol ceilings, which the block does not enforce. The two requests leave the block as registered one-clock pulses, meant for the pin-level signalling logic. An end strobe from that logic returns the block to idle.

Top module: `tgt_wait_timer`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) drives both request outputs low and leaves both timers unloaded; a start strobe sampled together with reset has no effect.
- R2: On a read (`is_write`=0 at start), with retry limit L and `rd_data_ready` held low, `retry_req` is first high in the clock cycle that follows the (L+2)-th rising edge counted from the edge that sampled `txn_start` (that edge counts as the first).
- R3: On a write (`is_write`=1 at start), the same retry timing applies with `wr_space_avail` as the wait condition; the flag of the other direction is ignored, so asserting only it still leads to a retry.
- R4: If the direction's ready flag is sampled high at any of the L+1 edges after the start edge, no retry is issued for that transaction, and the retry timer stays stopped from then on.
- R5: Once the ready flag has been seen, the disconnect timer loads disconnect limit D; each `beat_xfer` sampled in the data phase reloads it. If the next beat is not sampled within D+1 edges after the last load, `disconnect_req` is first high in the cycle after the (D+1)-th such edge.
- R6: A limit of 0 expires at the first edge of waiting: retry is seen one cycle after the first edge that follows start, and disconnect one cycle after the first edge that follows the load.
- R7: Each request is a single-cycle pulse. The two never overlap, and at most one of them is issued per transaction.
- R8: `txn_end` without `txn_start` clears the timers and suppresses any later request; if `txn_start` and `txn_end` are sampled together, the start wins and a new transaction begins.
- R9: The retry limit is sampled only at the start edge and the disconnect limit only at each load; changes between loads have no effect on timing.
- R10: The full limit value 255 is honoured for both timers at the default width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| txn_start | input | 1 | One-cycle strobe opening a transaction |
| txn_end | input | 1 | Strobe closing the current transaction |
| is_write | input | 1 | Direction at start: 1 write, 0 read |
| rd_data_ready | input | 1 | First read data is available |
| wr_space_avail | input | 1 | Target input buffer has room |
| beat_xfer | input | 1 | A data beat completed this cycle |
| retry_limit | input | LIM_W | Retry wait limit in clocks |
| disc_limit | input | LIM_W | Inter-beat wait limit in clocks |
| retry_req | output | 1 | One-cycle retry request |
| disconnect_req | output | 1 | One-cycle disconnect request |

## Verification
The bench builds the main instance with `LIM_W`=4. This makes every retry and disconnect limit from 0 to 15 reachable in a short run. Each limit is swept for reads and writes, with the ready flag arriving on the last allowed edge, one edge late, never, or only on the wrong direction's flag. A second instance at the default width of 8 reaches the 255-clock limit for both timers, so the full programmable range is checked without sweeping all of it.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FIRST = 2'd1,
        PH_DATA  = 2'd2,
        PH_DONE  = 2'd3
    } tw_phase_e;

    typedef struct packed {
        tw_phase_e phase;
        logic      dir_wr;
        logic      retry;
        logic      disc;
    } tw_ctrl_s;

endpackage

// File: rtl/tw_down_timer.sv
module tw_down_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         load,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expired
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } tmr_s;

    tmr_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = limit;
        end else if (clear) begin
            st_d.cnt = '0;
        end else if (run && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        expired = run && !load && (st_q.cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tw_phase_ctrl.sv
module tw_phase_ctrl
    import tw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic stop,
    input  logic is_write,
    input  logic rd_ready,
    input  logic wr_space,
    input  logic beat,
    input  logic retry_exp,
    input  logic disc_exp,
    output logic retry_load,
    output logic retry_run,
    output logic retry_clear,
    output logic disc_load,
    output logic disc_run,
    output logic disc_clear,
    output logic retry_pulse,
    output logic disc_pulse
);

    tw_ctrl_s st_d, st_q;
    logic     dir_rdy;
    logic     live;

    always_comb begin
        dir_rdy     = st_q.dir_wr ? wr_space : rd_ready;
        live        = !start && !stop;

        retry_load  = start;
        retry_run   = live && (st_q.phase == PH_FIRST) && !dir_rdy;
        disc_load   = live && (((st_q.phase == PH_FIRST) && dir_rdy) ||
                               ((st_q.phase == PH_DATA)  && beat));
        disc_run    = live && (st_q.phase == PH_DATA) && !beat;
        retry_clear = stop || (live && (st_q.phase == PH_FIRST) && dir_rdy);
        disc_clear  = stop || start;

        st_d        = st_q;
        st_d.retry  = 1'b0;
        st_d.disc   = 1'b0;
        if (start) begin
            st_d.phase  = PH_FIRST;
            st_d.dir_wr = is_write;
        end else if (stop) begin
            st_d.phase  = PH_IDLE;
        end else begin
            unique case (st_q.phase)
                PH_FIRST: begin
                    if (dir_rdy) begin
                        st_d.phase = PH_DATA;
                    end else if (retry_exp) begin
                        st_d.phase = PH_DONE;
                        st_d.retry = 1'b1;
                    end
                end
                PH_DATA: begin
                    if (!beat && disc_exp) begin
                        st_d.phase = PH_DONE;
                        st_d.disc  = 1'b1;
                    end
                end
                default: begin
                    st_d.phase = st_q.phase;
                end
            endcase
        end

        retry_pulse = st_q.retry;
        disc_pulse  = st_q.disc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{phase: PH_IDLE, dir_wr: 1'b0, retry: 1'b0, disc: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tgt_wait_timer.sv
module tgt_wait_timer #(
    parameter int LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             txn_start,
    input  logic             txn_end,
    input  logic             is_write,
    input  logic             rd_data_ready,
    input  logic             wr_space_avail,
    input  logic             beat_xfer,
    input  logic [LIM_W-1:0] retry_limit,
    input  logic [LIM_W-1:0] disc_limit,
    output logic             retry_req,
    output logic             disconnect_req
);

    logic retry_load, retry_run, retry_clear, retry_exp;
    logic disc_load, disc_run, disc_clear, disc_exp;

    tw_phase_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (txn_start),
        .stop        (txn_end),
        .is_write    (is_write),
        .rd_ready    (rd_data_ready),
        .wr_space    (wr_space_avail),
        .beat        (beat_xfer),
        .retry_exp   (retry_exp),
        .disc_exp    (disc_exp),
        .retry_load  (retry_load),
        .retry_run   (retry_run),
        .retry_clear (retry_clear),
        .disc_load   (disc_load),
        .disc_run    (disc_run),
        .disc_clear  (disc_clear),
        .retry_pulse (retry_req),
        .disc_pulse  (disconnect_req)
    );

    tw_down_timer #(.W(LIM_W)) u_retry_tmr (
        .clk     (clk),
        .rst     (rst),
        .clear   (retry_clear),
        .load    (retry_load),
        .run     (retry_run),
        .limit   (retry_limit),
        .expired (retry_exp)
    );

    tw_down_timer #(.W(LIM_W)) u_disc_tmr (
        .clk     (clk),
        .rst     (rst),
        .clear   (disc_clear),
        .load    (disc_load),
        .run     (disc_run),
        .limit   (disc_limit),
        .expired (disc_exp)
    );

endmodule

// File: rtl/tw_timer_checker.sv
module tw_timer_checker (
    input logic clk,
    input logic rst,
    input logic txn_start,
    input logic txn_end,
    input logic retry_run,
    input logic disc_run,
    input logic retry_req,
    input logic disconnect_req
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!retry_req && !disconnect_req));

    assert_start_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        txn_start |=> !retry_req);

    assert_retry_after_wait_R4: assert property (@(posedge clk) disable iff (rst)
        retry_req |-> $past(retry_run));

    assert_disc_after_gap_R5: assert property (@(posedge clk) disable iff (rst)
        disconnect_req |-> $past(disc_run));

    assert_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(retry_req && disconnect_req));

    assert_retry_single_R7: assert property (@(posedge clk) disable iff (rst)
        retry_req |=> !retry_req);

    assert_disc_single_R7: assert property (@(posedge clk) disable iff (rst)
        disconnect_req |=> !disconnect_req);

    assert_end_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (txn_end && !txn_start) |=> (!retry_req && !disconnect_req));

endmodule

bind tgt_wait_timer tw_timer_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .txn_start      (txn_start),
    .txn_end        (txn_end),
    .retry_run      (retry_run),
    .disc_run       (disc_run),
    .retry_req      (retry_req),
    .disconnect_req (disconnect_req)
);

// File: tb/tgt_wait_timer_bench.sv
module tgt_wait_timer_bench;

    localparam int LW = 4;
    localparam int MAXL = (1 << LW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic txn_start = 1'b0;
    logic txn_end = 1'b0;
    logic is_write = 1'b0;
    logic rd_data_ready = 1'b0;
    logic wr_space_avail = 1'b0;
    logic beat_xfer = 1'b0;
    logic [LW-1:0] retry_limit = '0;
    logic [LW-1:0] disc_limit = '0;
    logic [7:0] w_rlim = '0;
    logic [7:0] w_dlim = '0;
    logic retry_req, disconnect_req, w_retry, w_disc;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tgt_wait_timer #(.LIM_W(LW)) u_tgt_wait_timer (
        .clk(clk), .rst(rst), .txn_start(txn_start), .txn_end(txn_end),
        .is_write(is_write), .rd_data_ready(rd_data_ready),
        .wr_space_avail(wr_space_avail), .beat_xfer(beat_xfer),
        .retry_limit(retry_limit), .disc_limit(disc_limit),
        .retry_req(retry_req), .disconnect_req(disconnect_req)
    );

    tgt_wait_timer u_tgt_wait_timer_w8 (
        .clk(clk), .rst(rst), .txn_start(txn_start), .txn_end(txn_end),
        .is_write(is_write), .rd_data_ready(rd_data_ready),
        .wr_space_avail(wr_space_avail), .beat_xfer(beat_xfer),
        .retry_limit(w_rlim), .disc_limit(w_dlim),
        .retry_req(w_retry), .disconnect_req(w_disc)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_retry(int rlim, int rdy_at, bit wrong);
        if (wrong || rdy_at == 0 || rdy_at > rlim + 1) return rlim + 2;
        return 0;
    endfunction

    function automatic int exp_disc(int rlim, int dlim, int rdy_at, int beat_at, bit wrong);
        int last;
        if (exp_retry(rlim, rdy_at, wrong) != 0) return 0;
        last = (beat_at > rdy_at) ? beat_at : rdy_at;
        return last + dlim + 2;
    endfunction

    // One transaction. Index i counts falling edges after the start edge;
    // inputs set at index i are sampled by the (i)-th edge after start.
    task automatic run_case(input string req, input bit wide, input bit dir,
                            input int rlim, input int dlim, input int rdy_at,
                            input int beat_at, input bit wrong, input int end_at,
                            input bit end_with_start, input int chg_at,
                            input int new_rlim, input int new_dlim,
                            input int exp_r, input int exp_d, input int steps);
        int r_idx = 0, d_idx = 0, r_cnt = 0, d_cnt = 0;
        if (wide) begin
            w_rlim = 8'(rlim); w_dlim = 8'(dlim);
        end else begin
            retry_limit = LW'(rlim); disc_limit = LW'(dlim);
        end
        @(negedge clk);
        txn_start = 1'b1; txn_end = end_with_start; is_write = dir;
        rd_data_ready = 1'b0; wr_space_avail = 1'b0; beat_xfer = 1'b0;
        for (int i = 1; i <= steps; i++) begin
            logic rq, dq, rdy;
            @(negedge clk);
            rq = wide ? w_retry : retry_req;
            dq = wide ? w_disc : disconnect_req;
            if (rq) begin r_cnt++; if (r_idx == 0) r_idx = i; end
            if (dq) begin d_cnt++; if (d_idx == 0) d_idx = i; end
            txn_start = 1'b0;
            txn_end = (i == end_at);
            rdy = (rdy_at != 0) && (i >= rdy_at);
            if (wrong ^ dir) begin
                wr_space_avail = rdy; rd_data_ready = 1'b0;
            end else begin
                rd_data_ready = rdy; wr_space_avail = 1'b0;
            end
            beat_xfer = (i == beat_at);
            if (i == chg_at) begin
                if (wide) begin w_rlim = 8'(new_rlim); w_dlim = 8'(new_dlim); end
                else begin retry_limit = LW'(new_rlim); disc_limit = LW'(new_dlim); end
            end
        end
        check(r_idx == exp_r, {req, " retry timing"}, r_idx, exp_r);
        check(r_cnt == (exp_r != 0 ? 1 : 0), {req, " retry pulse count R7"}, r_cnt, (exp_r != 0 ? 1 : 0));
        check(d_idx == exp_d, {req, " disconnect timing"}, d_idx, exp_d);
        check(d_cnt == (exp_d != 0 ? 1 : 0), {req, " disconnect pulse count R7"}, d_cnt, (exp_d != 0 ? 1 : 0));
        txn_end = 1'b1; rd_data_ready = 1'b0; wr_space_avail = 1'b0; beat_xfer = 1'b0;
        @(negedge clk);
        txn_end = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset holds outputs low even with a start strobe
        txn_start = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(!retry_req && !disconnect_req, "R1 reset quiet", int'(retry_req | disconnect_req), 0);
        end
        rst = 1'b0; txn_start = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check(!retry_req && !disconnect_req, "R1 idle after reset", int'(retry_req | disconnect_req), 0);
        end

        // R2 R3 R4 R6: retry sweep over every limit and both directions
        for (int d = 0; d < 2; d++) begin
            for (int l = 0; l <= MAXL; l++) begin
                int ra [3];
                ra[0] = 0; ra[1] = l + 1; ra[2] = l + 2;
                for (int k = 0; k < 3; k++) begin
                    run_case(d ? "R3 write" : "R2 read", 1'b0, d[0], l, 3, ra[k], 0, 1'b0,
                             0, 1'b0, 0, 0, 0,
                             exp_retry(l, ra[k], 1'b0), exp_disc(l, 3, ra[k], 0, 1'b0), 56);
                end
                run_case("R3 other flag ignored", 1'b0, d[0], l, 3, 1, 0, 1'b1,
                         0, 1'b0, 0, 0, 0, exp_retry(l, 1, 1'b1), 0, 56);
            end
        end

        // R4: ready in the middle; R5 R6: disconnect sweep with boundary reload
        for (int l = 0; l <= MAXL; l++) begin
            run_case("R4 early ready", 1'b0, 1'b0, 7, l, 3, 0, 1'b0, 0, 1'b0, 0, 0, 0,
                     0, exp_disc(7, l, 3, 0, 1'b0), 56);
            run_case("R5 no beat", 1'b0, 1'b1, 2, l, 2, 0, 1'b0, 0, 1'b0, 0, 0, 0,
                     0, exp_disc(2, l, 2, 0, 1'b0), 56);
            run_case("R5 last-edge beat", 1'b0, 1'b0, 2, l, 2, l + 3, 1'b0, 0, 1'b0, 0, 0, 0,
                     0, exp_disc(2, l, 2, l + 3, 1'b0), 56);
            run_case("R5 late beat", 1'b0, 1'b1, 2, l, 2, l + 4, 1'b0, 0, 1'b0, 0, 0, 0,
                     0, l + 4, 56);
        end

        // R8: end mid-wait, end mid-data, and start+end together
        run_case("R8 end during retry wait", 1'b0, 1'b0, 10, 3, 0, 0, 1'b0, 4, 1'b0, 0, 0, 0, 0, 0, 56);
        run_case("R8 end during data", 1'b0, 1'b1, 10, 6, 1, 0, 1'b0, 5, 1'b0, 0, 0, 0, 0, 0, 56);
        run_case("R8 start beats end", 1'b0, 1'b0, 5, 3, 0, 0, 1'b0, 0, 1'b1, 0, 0, 0, 7, 0, 56);

        // R9: limits changed after their load have no effect
        run_case("R9 retry limit late change", 1'b0, 1'b0, 3, 3, 0, 0, 1'b0, 0, 1'b0, 2, 15, 3, 5, 0, 56);
        run_case("R9 disc limit late change", 1'b0, 1'b1, 8, 3, 1, 0, 1'b0, 0, 1'b0, 2, 8, 12, 0, 6, 56);
        run_case("R9 disc limit used at reload", 1'b0, 1'b0, 8, 3, 1, 4, 1'b0, 0, 1'b0, 2, 8, 12, 0, 18, 56);

        // R10: full range at default width
        run_case("R10 retry 255", 1'b1, 1'b0, 255, 0, 0, 0, 1'b0, 0, 1'b0, 0, 0, 0, 257, 0, 270);
        run_case("R10 disc 255", 1'b1, 1'b1, 255, 255, 1, 0, 1'b0, 0, 1'b0, 0, 0, 0, 0, 258, 270);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule